// File: doc/BRIEF.md
# Overlaid Byte/Word Register File

This block holds sixteen 8-bit registers that a small 8-bit processor uses for data and for addresses. Two byte read ports feed the ALU operands. A third read port gives a 16-bit view for address and jump-base values, and one byte write port with an enable takes results back.

In the 16-bit view the lower indices return their single byte register zero-extended. Each of the upper six indices instead joins two adjacent byte registers into one big-endian word: the even register gives the high byte and the odd register gives the low byte. Register zero is wired to zero in every view, and any write to it is dropped. Writes take effect on the clock edge. All reads are combinational.

Top module: `regFile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets every register to zero, so every index reads 0 on all three read ports.
- R2: A write with `wrEn` high and `wrIdx` not zero stores `wrData` at the rising edge. From the next cycle that value reads back on both byte ports at that index.
- R3: When `wrEn` is low, a clock edge changes no register.
- R4: Index 0 reads 0x00 on both byte ports and 0x0000 on the word port, even after a write to index 0.
- R5: A word read with index 0x0 to 0x9 returns the byte register of that index in bits 7:0, with bits 15:8 zero.
- R6: A word read with index 0xA+k (k = 0 to 5) returns register 4+2k in bits 15:8 and register 5+2k in bits 7:0. For example, 0xA gives {R4,R5} and 0xF gives {R14,R15}.
- R7: Read ports are combinational: a change of read index shows the new register value in the same cycle, with no clock edge.
- R8: A write changes only the addressed register. All the other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Write register index |
| wrData | input | 8 | Write data |
| rdIdxX | input | 4 | First byte read index |
| rdDataX | output | 8 | First byte read data |
| rdIdxY | input | 4 | Second byte read index |
| rdDataY | output | 8 | Second byte read data |
| rdIdxW | input | 4 | Word read index |
| rdDataW | output | 16 | Word read data |

## Verification
The reads are combinational, so a register holding a wrong value shows on any read port as soon as that index is selected. A lost or misdirected write is therefore seen one cycle after the write edge, on the byte ports and also inside every word that pairs that register. A swapped or shifted pair mapping gives a wrong byte in one half of a word read. A missing zero-extension leaves non-zero upper bits on the low word indices. Register zero leaking a written value appears on the cycle right after the write to index 0.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int REG_W       = 8;
  localparam int REG_N       = 16;
  localparam int IDX_W       = $clog2(REG_N);
  localparam int WORD_W      = 2 * REG_W;
  localparam int PAIR_BASE   = 10;  // first word index that joins two bytes
  localparam int PAIR_HI_REG = 4;   // even register feeding the first pair

  typedef struct packed {
    logic [REG_N-1:0] sel;   // one-hot register write select
    logic [REG_W-1:0] data;  // byte to store
  } wrStrobe_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [REG_W-1:0] wrData,
  output wrStrobe_t        strobe
);
  always_comb begin
    strobe.sel  = '0;
    strobe.data = wrData;
    // index zero is hard-wired, so it never gets a strobe
    if (wrEn && (wrIdx != '0)) strobe.sel[wrIdx] = 1'b1;
  end
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [IDX_W-1:0]  rdIdxX,
  input  logic [IDX_W-1:0]  rdIdxY,
  input  logic [IDX_W-1:0]  rdIdxW,
  output logic [REG_W-1:0]  rdDataX,
  output logic [REG_W-1:0]  rdDataY,
  output logic [WORD_W-1:0] rdDataW
);
  logic [REG_W-1:0]  byteView [REG_N];
  logic [WORD_W-1:0] wordView [REG_N];

  assign byteView[0] = '0;

  for (genvar g = 1; g < REG_N; g++) begin : g_store
    logic [REG_W-1:0] regQ;
    always_ff @(posedge clk) begin
      if (rst)               regQ <= '0;
      else if (strobe.sel[g]) regQ <= strobe.data;
    end
    assign byteView[g] = regQ;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
      strobe.sel[g] |=> byteView[g] == $past(strobe.data));
    assert_hold_unselected_R8: assert property (@(posedge clk) disable iff (rst)
      !strobe.sel[g] |=> $stable(byteView[g]));
  end

  for (genvar g = 0; g < REG_N; g++) begin : g_word
    if (g < PAIR_BASE) begin : g_ext
      assign wordView[g] = {{REG_W{1'b0}}, byteView[g]};
    end else begin : g_pair
      localparam int HI = PAIR_HI_REG + 2 * (g - PAIR_BASE);
      assign wordView[g] = {byteView[HI], byteView[HI+1]};
    end
  end

  assign rdDataX = byteView[rdIdxX];
  assign rdDataY = byteView[rdIdxY];
  assign rdDataW = wordView[rdIdxW];

  assert_reg_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rdIdxX == '0) |-> (rdDataX == '0));
endmodule

// File: rtl/regFile.sv
module regFile
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [REG_W-1:0]  wrData,
  input  logic [IDX_W-1:0]  rdIdxX,
  output logic [REG_W-1:0]  rdDataX,
  input  logic [IDX_W-1:0]  rdIdxY,
  output logic [REG_W-1:0]  rdDataY,
  input  logic [IDX_W-1:0]  rdIdxW,
  output logic [WORD_W-1:0] rdDataW
);
  wrStrobe_t strobe;

  regfile_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .strobe (strobe)
  );

  regfile_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .rdIdxX  (rdIdxX),
    .rdIdxY  (rdIdxY),
    .rdIdxW  (rdIdxW),
    .rdDataX (rdDataX),
    .rdDataY (rdDataY),
    .rdDataW (rdDataW)
  );

  // cross-port checks between the byte and word views
  assert_word_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(rdIdxW) < PAIR_BASE && rdIdxW == rdIdxX)
      |-> (rdDataW == {{REG_W{1'b0}}, rdDataX}));
  assert_pair_high_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(rdIdxW) >= PAIR_BASE &&
     int'(rdIdxX) == PAIR_HI_REG + 2 * (int'(rdIdxW) - PAIR_BASE))
      |-> (rdDataW[WORD_W-1:REG_W] == rdDataX));
  assert_pair_low_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(rdIdxW) >= PAIR_BASE &&
     int'(rdIdxY) == PAIR_HI_REG + 2 * (int'(rdIdxW) - PAIR_BASE) + 1)
      |-> (rdDataW[REG_W-1:0] == rdDataY));
endmodule

// File: tb/sim_regFile.sv
`timescale 1ns/1ps
module sim_regFile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [7:0]  wrData = '0;
  logic [3:0]  rdIdxX = '0, rdIdxY = '0, rdIdxW = '0;
  logic [7:0]  rdDataX, rdDataY;
  logic [15:0] rdDataW;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  regFile u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdxX(rdIdxX), .rdDataX(rdDataX), .rdIdxY(rdIdxY), .rdDataY(rdDataY),
    .rdIdxW(rdIdxW), .rdDataW(rdDataW)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wordOf(input int i);
    if (i < 10) return {8'h00, model[i]};
    return {model[4 + 2*(i-10)], model[5 + 2*(i-10)]};
  endfunction

  task automatic writeReg(input int idx, input logic [7:0] d, input bit en);
    @(negedge clk);
    wrEn = en; wrIdx = idx[3:0]; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    if (en && idx != 0) model[idx] = d;
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 16; i++) begin
      rdIdxX = i[3:0]; rdIdxY = i[3:0]; rdIdxW = i[3:0];
      #1;
      chk(req, {8'h00, rdDataX}, {8'h00, model[i]});
      chk(req, {8'h00, rdDataY}, {8'h00, model[i]});
      chk(req, rdDataW, wordOf(i));
    end
  endtask

  task automatic tReset();  // R1
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkAll("R1 reset");
  endtask

  task automatic tWriteAll();  // R2, R5, R6
    for (int i = 1; i < 16; i++) writeReg(i, 8'(i * 8'h13 + 8'h21), 1'b1);
    checkAll("R2/R5/R6 all");
    rdIdxW = 4'hA; #1; chk("R6 pair A", rdDataW, {model[4], model[5]});
    rdIdxW = 4'hF; #1; chk("R6 pair F", rdDataW, {model[14], model[15]});
    rdIdxW = 4'h9; #1; chk("R5 ext 9", rdDataW, {8'h00, model[9]});
  endtask

  task automatic tZeroReg();  // R4
    writeReg(0, 8'hFF, 1'b1);
    rdIdxX = 0; rdIdxY = 0; rdIdxW = 0; #1;
    chk("R4 byteX", {8'h00, rdDataX}, 16'h0000);
    chk("R4 byteY", {8'h00, rdDataY}, 16'h0000);
    chk("R4 word", rdDataW, 16'h0000);
  endtask

  task automatic tDisabled();  // R3
    writeReg(7, 8'hC3, 1'b0);
    checkAll("R3 no enable");
  endtask

  task automatic tSingle();  // R8
    writeReg(12, 8'h5E, 1'b1);
    checkAll("R8 single write");
  endtask

  task automatic tComb();  // R7
    @(negedge clk);
    rdIdxX = 4'h3; rdIdxW = 4'hD; #1;
    chk("R7 comb X", {8'h00, rdDataX}, {8'h00, model[3]});
    chk("R7 comb W", rdDataW, wordOf(13));
    rdIdxX = 4'hB; rdIdxW = 4'h2; #1;
    chk("R7 comb X2", {8'h00, rdDataX}, {8'h00, model[11]});
    chk("R7 comb W2", rdDataW, wordOf(2));
  endtask

  initial begin
    tReset();
    tWriteAll();
    tZeroReg();
    tDisabled();
    tSingle();
    tComb();
    tReset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule